// File: doc/BRIEF.md
# Serial single-step debug controller

This block wraps a small piece of logic under test behind a clock enable and hands control of that enable to a host on a serial line. The logic under test is a 4-bit counter that drives the LED outputs and a 16-bit event counter. Neither moves by itself. The host sends one command byte per frame. A step command advances both counters by exactly one. Read commands return a snapshot of either counter. Every command byte, known or not, is answered with exactly one reply byte.

The serial format is 8N1: one low start bit, eight data bits sent least significant bit first, no parity, and one high stop bit. The bit period is `CLKS_PER_BIT` clock cycles.

The receiver has five states:
- `RX_IDLE` waits for a low level and then moves to `RX_START`.
- `RX_START` confirms the start bit at its midpoint. It moves to `RX_DATA`, or goes back to `RX_IDLE` if the line was only a glitch.
- `RX_DATA` samples eight bits at their midpoints and then moves to `RX_STOP`.
- `RX_STOP` emits the byte and returns to `RX_IDLE` when the stop bit is high. When the stop bit is low it drops the byte and moves to `RX_RECOVER`.
- `RX_RECOVER` waits for the line to go high again and then returns to `RX_IDLE`.

The transmitter runs `TX_IDLE`, then `TX_START`, then `TX_DATA`, then `TX_STOP`, and back to `TX_IDLE`.

The reply holder has two states:
- `RPL_EMPTY` moves to `RPL_FULL` when a byte arrives.
- `RPL_FULL` hands the reply to the transmitter once it is idle and goes back to `RPL_EMPTY`. If a new byte arrives in that same cycle, the holder stays in `RPL_FULL` with the new reply.

Top module: `dbg_step_ctrl`

## Requirements
- R1: The LED counter (4 bits) and the event counter (16 bits) each increase by exactly one, wrapping modulo their width, in the clock cycle after a cycle with the step enable high. They do not change in any other cycle.
- R2: A received byte 0x00 is the step command. It raises the step enable for exactly one cycle, in the cycle after the receiver's byte-valid strobe.
- R3: Every byte accepted by the receiver causes exactly one reply byte to be sent on `tx_o`.
- R4: Command 0x00 replies 0x00. Command 0x01 replies with the LED counter, zero-extended to 8 bits.
- R5: Command 0x02 replies with bits 7:0 of the event counter. Any other command value replies 0x00.
- R6: A byte other than 0x00 changes neither counter.
- R7: Frames on both lines are 8N1: start bit 0, data bits least significant first, stop bit 1. `tx_o` is high whenever the transmitter is idle.
- R8: A received frame whose stop bit is low is discarded. It produces no reply and no step.
- R9: A synchronous active-high `rst` clears both counters, empties the reply holder and returns `tx_o` to its idle high level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial command input, idle high |
| tx_o | output | 1 | Serial reply output, idle high |
| led_o | output | LED_W (4) | LED counter of the logic under test |

## Verification
The bench builds the block with `CLKS_PER_BIT` = 8 instead of the default 104. This makes a frame take only 80 clocks, so a run of about three hundred step commands fits in the cycle budget. That run carries the 4-bit LED counter through many wraps and the low byte of the event counter past 255, so the value read back depends on correct modulo behaviour. The small divisor also makes it cheap to inject a frame with a low stop bit and then watch a long quiet window for any stray reply or LED change.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam logic [7:0] CMD_STEP   = 8'h00;
    localparam logic [7:0] CMD_RD_LED = 8'h01;
    localparam logic [7:0] CMD_RD_CNT = 8'h02;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_RECOVER
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    typedef enum logic {
        RPL_EMPTY,
        RPL_FULL
    } rpl_state_t;

endpackage

// File: rtl/dbg_uart_rx.sv
module dbg_uart_rx
    import dbg_pkg::*;
#(
    parameter int CLKS_PER_BIT = 104,
    parameter int DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int CW = $clog2(CLKS_PER_BIT);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST_TICK = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF_TICK = CW'(CLKS_PER_BIT / 2 - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_W - 1);

    logic              sync1_q, sync2_q;
    rx_state_t         state_q, state_d;
    logic [CW-1:0]     tick_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              valid_q;

    // two-stage synchroniser, idle high
    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= rx_i;
            sync2_q <= sync1_q;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:    if (!sync2_q) state_d = RX_START;
            RX_START:   if (tick_q == HALF_TICK)
                            state_d = sync2_q ? RX_IDLE : RX_DATA;
            RX_DATA:    if (tick_q == LAST_TICK && bit_q == LAST_BIT)
                            state_d = RX_STOP;
            RX_STOP:    if (tick_q == LAST_TICK)
                            state_d = sync2_q ? RX_IDLE : RX_RECOVER;
            RX_RECOVER: if (sync2_q) state_d = RX_IDLE;
            default:    state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= RX_IDLE;
        else     state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q  <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    tick_q <= '0;
                    bit_q  <= '0;
                end
                RX_START: begin
                    tick_q <= (tick_q == HALF_TICK) ? '0 : tick_q + 1'b1;
                end
                RX_DATA: begin
                    if (tick_q == LAST_TICK) begin
                        tick_q  <= '0;
                        shift_q <= {sync2_q, shift_q[DATA_W-1:1]};
                        bit_q   <= bit_q + 1'b1;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (tick_q == LAST_TICK) begin
                        tick_q  <= '0;
                        valid_q <= sync2_q;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                RX_RECOVER: tick_q <= '0;
                default:    tick_q <= '0;
            endcase
        end
    end

    assign valid_o = valid_q;
    assign data_o  = shift_q;

endmodule

// File: rtl/dbg_uart_tx.sv
module dbg_uart_tx
    import dbg_pkg::*;
#(
    parameter int CLKS_PER_BIT = 104,
    parameter int DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              tx_o,
    output logic              busy_o
);

    localparam int CW = $clog2(CLKS_PER_BIT);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST_TICK = CW'(CLKS_PER_BIT - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_W - 1);

    tx_state_t         state_q, state_d;
    logic [CW-1:0]     tick_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              line_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (start_i) state_d = TX_START;
            TX_START: if (tick_q == LAST_TICK) state_d = TX_DATA;
            TX_DATA:  if (tick_q == LAST_TICK && bit_q == LAST_BIT)
                          state_d = TX_STOP;
            TX_STOP:  if (tick_q == LAST_TICK) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q  <= '0;
            bit_q   <= '0;
            shift_q <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    tick_q <= '0;
                    bit_q  <= '0;
                    if (start_i) shift_q <= data_i;
                end
                TX_START: begin
                    tick_q <= (tick_q == LAST_TICK) ? '0 : tick_q + 1'b1;
                end
                TX_DATA: begin
                    if (tick_q == LAST_TICK) begin
                        tick_q  <= '0;
                        bit_q   <= bit_q + 1'b1;
                        shift_q <= {1'b0, shift_q[DATA_W-1:1]};
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                TX_STOP: begin
                    tick_q <= (tick_q == LAST_TICK) ? '0 : tick_q + 1'b1;
                end
                default: tick_q <= '0;
            endcase
        end
    end

    // registered line level, decoded from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b1;
        end else begin
            unique case (state_d)
                TX_IDLE:  line_q <= 1'b1;
                TX_START: line_q <= 1'b0;
                TX_DATA:  line_q <= (state_q == TX_START) ? shift_q[0]
                                  : (tick_q == LAST_TICK) ? shift_q[1]
                                  : shift_q[0];
                TX_STOP:  line_q <= 1'b1;
                default:  line_q <= 1'b1;
            endcase
        end
    end

    always_comb begin
        busy_o = (state_q != TX_IDLE);
        tx_o   = line_q;
    end

endmodule

// File: rtl/dbg_cmd_decoder.sv
module dbg_cmd_decoder
    import dbg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LED_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic [LED_W-1:0]  led_i,
    input  logic [DATA_W-1:0] cnt_lo_i,
    input  logic              tx_busy_i,
    output logic              step_o,
    output logic              tx_start_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              rpl_full_o
);

    localparam int PAD_W = DATA_W - LED_W;

    rpl_state_t        state_q, state_d;
    logic [DATA_W-1:0] reply_q, reply_d;
    logic              step_q;
    logic              launch;

    // reply selection for the byte now arriving
    always_comb begin
        unique case (rx_data_i)
            CMD_STEP:   reply_d = '0;
            CMD_RD_LED: reply_d = {{PAD_W{1'b0}}, led_i};
            CMD_RD_CNT: reply_d = cnt_lo_i;
            default:    reply_d = '0;
        endcase
    end

    assign launch = (state_q == RPL_FULL) && !tx_busy_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RPL_EMPTY: if (rx_valid_i) state_d = RPL_FULL;
            RPL_FULL:  if (launch && !rx_valid_i) state_d = RPL_EMPTY;
            default:   state_d = RPL_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RPL_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reply_q <= '0;
            step_q  <= 1'b0;
        end else begin
            step_q <= rx_valid_i && (rx_data_i == CMD_STEP);
            if (rx_valid_i) reply_q <= reply_d;
        end
    end

    always_comb begin
        step_o     = step_q;
        tx_start_o = launch;
        tx_data_o  = reply_q;
        rpl_full_o = (state_q == RPL_FULL);
    end

endmodule

// File: rtl/dbg_step_logic.sv
module dbg_step_logic #(
    parameter int LED_W  = 4,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    output logic [LED_W-1:0]  led_o,
    output logic [DATA_W-1:0] cnt_lo_o
);

    logic [LED_W-1:0] led_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q <= '0;
            cnt_q <= '0;
        end else if (step_i) begin
            led_q <= led_q + 1'b1;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign led_o    = led_q;
    assign cnt_lo_o = cnt_q[DATA_W-1:0];

endmodule

// File: rtl/dbg_step_ctrl.sv
module dbg_step_ctrl #(
    parameter int CLKS_PER_BIT = 104,
    parameter int DATA_W       = 8,
    parameter int LED_W        = 4,
    parameter int CNT_W        = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_i,
    output logic             tx_o,
    output logic [LED_W-1:0] led_o
);

    logic              rx_valid;
    logic [DATA_W-1:0] rx_byte;
    logic              step_en;
    logic [DATA_W-1:0] cnt_lo;
    logic              tx_busy;
    logic              tx_start;
    logic [DATA_W-1:0] tx_byte;
    logic              rpl_full;

    dbg_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .rx_i    (rx_i),
        .valid_o (rx_valid),
        .data_o  (rx_byte)
    );

    dbg_cmd_decoder #(.DATA_W(DATA_W), .LED_W(LED_W)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .rx_valid_i (rx_valid),
        .rx_data_i  (rx_byte),
        .led_i      (led_o),
        .cnt_lo_i   (cnt_lo),
        .tx_busy_i  (tx_busy),
        .step_o     (step_en),
        .tx_start_o (tx_start),
        .tx_data_o  (tx_byte),
        .rpl_full_o (rpl_full)
    );

    dbg_step_logic #(.LED_W(LED_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_lut (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step_en),
        .led_o    (led_o),
        .cnt_lo_o (cnt_lo)
    );

    dbg_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .start_i (tx_start),
        .data_i  (tx_byte),
        .tx_o    (tx_o),
        .busy_o  (tx_busy)
    );

endmodule

// File: rtl/dbg_step_ctrl_chk.sv
module dbg_step_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int LED_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_byte,
    input logic              step_en,
    input logic [LED_W-1:0]  led_o,
    input logic [DATA_W-1:0] cnt_lo,
    input logic              tx_o,
    input logic              tx_busy,
    input logic              tx_start,
    input logic              rpl_full
);

    AST_STEP_PULSE: assert property (@(posedge clk) disable iff (rst)
        step_en |=> !step_en); // R2

    AST_STEP_SOURCE: assert property (@(posedge clk) disable iff (rst)
        step_en |-> ($past(rx_valid) && $past(rx_byte) == '0)); // R2

    AST_LED_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (led_o == LED_W'($past(led_o) + 1'b1))); // R1

    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (cnt_lo == DATA_W'($past(cnt_lo) + 1'b1))); // R1

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> ($stable(led_o) && $stable(cnt_lo))); // R6

    AST_BYTE_QUEUES_REPLY: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> rpl_full); // R3

    AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> !tx_busy); // R3

    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> tx_o); // R7

endmodule

bind dbg_step_ctrl dbg_step_ctrl_chk #(.DATA_W(DATA_W), .LED_W(LED_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .step_en  (step_en),
    .led_o    (led_o),
    .cnt_lo   (cnt_lo),
    .tx_o     (tx_o),
    .tx_busy  (tx_busy),
    .tx_start (tx_start),
    .rpl_full (rpl_full)
);

// File: tb/sim_dbg_step_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_step_ctrl;

    localparam int CPB    = 8;
    localparam int LED_W  = 4;
    localparam int BIT_NS = CPB * 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx  = 1'b1;
    logic             tx;
    logic [LED_W-1:0] led;

    int  n_vec  = 0;
    int  n_bad  = 0;
    int  cycles = 0;
    bit  done   = 1'b0;

    // reference model state
    int        exp_steps = 0;
    bit        step_pending = 1'b0;
    logic [7:0] rx_q[$];
    logic [LED_W-1:0] prev_led = '0;

    always #5 clk = ~clk;

    dbg_step_ctrl #(.CLKS_PER_BIT(CPB), .LED_W(LED_W)) u0 (
        .clk   (clk),
        .rst   (rst),
        .rx_i  (rx),
        .tx_o  (tx),
        .led_o (led)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // per-clock model comparison of the LED output (R1, R6)
    always @(negedge clk) begin
        cycles++;
        if (!rst && led != prev_led) begin
            check(step_pending && led == LED_W'(prev_led + 1'b1), "R1/R6 led change",
                  led, LED_W'(prev_led + 1'b1));
            step_pending = 1'b0;
        end
        prev_led = led;
        if (cycles > 190000) begin
            check(1'b0, "R3 watchdog", cycles, 0);
            finish_run();
        end
    end

    // serial decoder for the reply line (R7)
    initial begin
        forever begin
            logic [7:0] b;
            @(negedge tx);
            #(BIT_NS / 2 + 2);
            if (tx !== 1'b0) check(1'b0, "R7 start bit", tx, 0);
            for (int i = 0; i < 8; i++) begin
                #(BIT_NS);
                b[i] = tx;
            end
            #(BIT_NS);
            check(tx === 1'b1, "R7 stop bit", tx, 1);
            rx_q.push_back(b);
        end
    end

    task automatic send_frame(input logic [7:0] b, input bit stop_ok);
        @(negedge clk) rx = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (CPB) @(negedge clk);
        end
        rx = stop_ok;
        repeat (CPB) @(negedge clk);
        rx = 1'b1;
        repeat (2 * CPB) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] b, input logic [7:0] exp, input string req);
        int wait_n = 0;
        if (b == 8'h00) step_pending = 1'b1;
        send_frame(b, 1'b1);
        while (rx_q.size() == 0 && wait_n < 40 * CPB) begin
            @(negedge clk);
            wait_n++;
        end
        if (rx_q.size() == 0) begin
            check(1'b0, {req, " R3 no reply"}, 0, exp);
        end else begin
            logic [7:0] got = rx_q.pop_front();
            check(got == exp, req, got, exp);
        end
        if (b == 8'h00) begin
            exp_steps++;
            check(led == LED_W'(exp_steps), "R1 led after step", led, LED_W'(exp_steps));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx === 1'b1, "R9 tx idle after reset", tx, 1);
        check(led == '0, "R9 led after reset", led, 0);
        cmd(8'h02, 8'h00, "R5 R9 count read after reset");
        cmd(8'h01, 8'h00, "R4 led read after reset");
        cmd(8'h05, 8'h00, "R5 unknown command reply");
        check(led == '0, "R6 led unchanged by 0x05", led, 0);

        for (int i = 0; i < 20; i++) cmd(8'h00, 8'h00, "R4 R2 step reply");
        cmd(8'h01, 8'(exp_steps % 16), "R4 led read after 20 steps");
        cmd(8'h02, 8'(exp_steps % 256), "R5 count read after 20 steps");

        // frame with a low stop bit: no reply, no step (R8)
        send_frame(8'h00, 1'b0);
        repeat (40 * CPB) @(negedge clk);
        check(rx_q.size() == 0, "R8 no reply to bad frame", rx_q.size(), 0);
        check(led == LED_W'(exp_steps), "R8 no step from bad frame", led, LED_W'(exp_steps));
        cmd(8'h02, 8'(exp_steps % 256), "R8 count unchanged by bad frame");

        cmd(8'hFF, 8'h00, "R5 R6 0xFF reply");
        cmd(8'h03, 8'h00, "R5 0x03 reply");
        cmd(8'h01, 8'(exp_steps % 16), "R6 led unchanged by reads");

        for (int i = 0; i < 281; i++) cmd(8'h00, 8'h00, "R2 step reply long run");
        cmd(8'h01, 8'(exp_steps % 16), "R1 led wrap after 301 steps");
        cmd(8'h02, 8'(exp_steps % 256), "R1 R5 count low byte after 301 steps");

        // reset in the middle of a run
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_steps = 0;
        @(negedge clk);
        prev_led = led;
        check(led == '0, "R9 led cleared mid-run", led, 0);
        check(tx === 1'b1, "R9 tx high after mid-run reset", tx, 1);
        cmd(8'h02, 8'h00, "R9 count cleared mid-run");
        cmd(8'h00, 8'h00, "R2 step after reset");
        cmd(8'h02, 8'h01, "R5 count one after reset");
        finish_run();
    end

endmodule